// File: doc/BRIEF.md
# Three-Channel Programmable Interval Counter

This block holds three independent 16-bit down counters behind a small byte-wide register port. A host selects a counter or the shared control register with two address bits, qualifies each access with an active-low chip select, and moves bytes with active-low read and write strobes. A control byte picks a counter and sets four things for it: how its count is transferred over the byte port, its operating mode, and whether it counts in binary or in four BCD digits.

Each counter has its own count clock, gate and output pin. Counting happens on falling edges of the count clock, which are detected in the system clock domain. The count clock and gate inputs must therefore be synchronous to `clk_i` and held for at least one system cycle per level. A newly written count moves into the counting element at the first falling count-clock edge after the write. A running count can be read live, or it can be frozen in a holding register and read back later, and neither way disturbs counting. Output waveforms are provided for terminal-count signalling, rate generation and square-wave generation.

Top module: `prog_interval_timer`

## Requirements
- R1: Address 3 is the control register. In a control byte, bits 7:6 pick the counter (3 is ignored) and bit 0 selects BCD counting. Bits 5:4 give the access format: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 give the mode. A single-byte format reads and writes only its own byte, and the other byte of a written count is zero.
- R2: While `cs_ni` is high, strobes have no effect and `data_oe_o` stays low. A read with `cs_ni` low drives the byte on `data_o` and raises `data_oe_o` from the cycle after the read strobe falls until the strobe rises.
- R3: A completed count write changes the counting element only at the first falling count-clock edge after the write. A read before that edge returns the previous count.
- R4: In the low-then-high format, reads and writes each alternate between the low and high byte, starting with the low byte. Writing a control byte to a counter resets both of its pointers to the low byte.
- R5: A latch command freezes the count until every byte of the access format has been read. A second latch command given while a value is frozen is ignored.
- R6: Reading a counter that is not frozen returns its current count and does not stop it or change it.
- R7: Mode 0 drives the output low when the control byte is written and when a count write completes. The output goes high when the count reaches zero and stays high while the counter wraps.
- R8: Modes 2 and 6 with count N repeat every N count edges. The output is low only for the edge interval in which the count equals 1, and then the count reloads N.
- R9: Modes 3 and 7 with count N drive the output high for ceil(N/2) count edges and low for floor(N/2) count edges, starting high.
- R10: In BCD counting the count steps through decimal digits, and 0000 wraps to 9999.
- R11: While a counter's gate is low, its count holds. In modes 2, 3, 6 and 7 a low gate also forces the output high one cycle later.
- R12: In modes 1, 4 and 5 the counter loads and decrements, and its output stays high.
- R13: Before a counter has received its first control byte, count writes to it are ignored and reads from it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| addr_i | input | 2 | Register select: counters 0 to 2, control at 3 |
| data_i | input | 8 | Write data byte |
| data_o | output | 8 | Read data byte, zero when not driving |
| data_oe_o | output | 1 | High while `data_o` carries read data |
| cnt_clk_i | input | NUM_CH | Count clock per counter, counted on falling edges |
| gate_i | input | NUM_CH | Count enable per counter |
| out_o | output | NUM_CH | Counter output per counter |

## Verification
The bench builds the block with its default of three counters. This makes every counter-select code reachable, including the ignored code 3. It drives separate count clocks and gates so that one counter runs in mode 0, one in the rate and BCD modes, and one in square-wave mode with an odd count. Expected bytes are computed in the bench and queued, and a monitor compares each one when `data_oe_o` rises. This covers live and frozen reads, pointer resets, wrap to all ones and to 9999, and strobes ignored while the chip is not selected.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    OP_TC,
    OP_RATE,
    OP_SQUARE,
    OP_PLAIN
  } op_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;

  function automatic op_e decode_op(logic [2:0] m);
    case (m)
      3'd0:        return OP_TC;
      3'd2, 3'd6:  return OP_RATE;
      3'd3, 3'd7:  return OP_SQUARE;
      default:     return OP_PLAIN;
    endcase
  endfunction

  // one step down, binary or four BCD digits (0000 wraps to 9999)
  function automatic logic [15:0] dec_one(logic [15:0] v, logic bcd);
    logic [15:0] r;
    logic        brw;
    logic [3:0]  d;
    if (!bcd) return v - 16'd1;
    r   = '0;
    brw = 1'b1;
    for (int i = 0; i < 4; i++) begin
      d = v[4*i +: 4];
      if (!brw) r[4*i +: 4] = d;
      else if (d == 4'd0) r[4*i +: 4] = 4'd9;
      else begin
        r[4*i +: 4] = d - 4'd1;
        brw = 1'b0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_bus.sv
module pit_bus
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   rd_ni,
  input  logic                   wr_ni,
  input  logic [1:0]             addr_i,
  input  logic [7:0]             data_i,
  input  logic [NUM_CH-1:0][7:0] rd_byte_i,
  output logic [NUM_CH-1:0]      wr_stb_o,
  output logic [NUM_CH-1:0]      rd_stb_o,
  output logic [NUM_CH-1:0]      cfg_stb_o,
  output logic [NUM_CH-1:0]      latch_stb_o,
  output ctl_t                   cfg_o,
  output logic [7:0]             wdata_o,
  output logic [7:0]             data_o,
  output logic                   data_oe_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [2:0] CH_LIM    = 3'(NUM_CH);

  logic       wr_prev_q, rd_prev_q, oe_q;
  logic [7:0] data_q;
  logic       wr_fall, rd_fall, addr_ch;
  logic [1:0] sel;

  assign wr_fall = wr_prev_q & ~wr_ni & ~cs_ni;
  assign rd_fall = rd_prev_q & ~rd_ni & ~cs_ni;
  assign addr_ch = {1'b0, addr_i} < CH_LIM;
  assign sel     = data_i[7:6];
  assign cfg_o   = ctl_t'(data_i[5:0]);
  assign wdata_o = data_i;

  always_comb begin
    wr_stb_o    = '0;
    rd_stb_o    = '0;
    cfg_stb_o   = '0;
    latch_stb_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_fall && addr_i == CTRL_ADDR && sel == 2'(c)) begin
        if (data_i[5:4] == ACC_LATCH) latch_stb_o[c] = 1'b1;
        else                          cfg_stb_o[c]   = 1'b1;
      end
      if (wr_fall && addr_i == 2'(c)) wr_stb_o[c] = 1'b1;
      if (rd_fall && addr_i == 2'(c)) rd_stb_o[c] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
      oe_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      wr_prev_q <= wr_ni;
      rd_prev_q <= rd_ni;
      oe_q      <= ~cs_ni & ~rd_ni;
      if (rd_fall) begin
        data_q <= '0;
        for (int c = 0; c < NUM_CH; c++)
          if (addr_ch && addr_i == 2'(c)) data_q <= rd_byte_i[c];
      end
    end
  end

  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? data_q : '0;
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_clk_i,
  input  logic       gate_i,
  input  logic       cfg_stb_i,
  input  ctl_t       cfg_i,
  input  logic       latch_stb_i,
  input  logic       wr_stb_i,
  input  logic       rd_stb_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rd_byte_o,
  output logic       out_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cr_q, ce_q, ol_q, src, dec1, dec2;
  logic             latched_q, wr_hi_q, rd_hi_q, pend_q, run_q, out_q, cnt_prev_q;
  logic             tick, wr_done;
  op_e              op;

  assign tick = cnt_prev_q & ~cnt_clk_i;
  assign op   = decode_op(ctl_q.mode);
  assign dec1 = dec_one(ce_q, ctl_q.bcd);
  assign dec2 = dec_one(dec1, ctl_q.bcd);
  assign src  = latched_q ? ol_q : ce_q;
  assign wr_done = wr_stb_i && (ctl_q.acc == ACC_LO || ctl_q.acc == ACC_HI ||
                                (ctl_q.acc == ACC_WORD && wr_hi_q));

  always_comb begin
    case (ctl_q.acc)
      ACC_LO:   rd_byte_o = src[7:0];
      ACC_HI:   rd_byte_o = src[15:8];
      ACC_WORD: rd_byte_o = rd_hi_q ? src[15:8] : src[7:0];
      default:  rd_byte_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      cr_q       <= '0;
      ce_q       <= '0;
      ol_q       <= '0;
      latched_q  <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      pend_q     <= 1'b0;
      run_q      <= 1'b0;
      out_q      <= 1'b1;
      cnt_prev_q <= 1'b0;
    end else begin
      cnt_prev_q <= cnt_clk_i;
      if (tick) begin
        if (pend_q) begin
          ce_q   <= cr_q;
          pend_q <= 1'b0;
          run_q  <= 1'b1;
        end else if (run_q && gate_i) begin
          case (op)
            OP_TC: begin
              ce_q <= dec1;
              if (ce_q == 16'd1) out_q <= 1'b1;
            end
            OP_RATE: begin
              if (ce_q == 16'd1) begin
                ce_q  <= cr_q;
                out_q <= 1'b1;
              end else begin
                ce_q  <= dec1;
                out_q <= (ce_q != 16'd2);
              end
            end
            OP_SQUARE: begin
              if (ce_q == 16'd2) begin
                out_q <= ~out_q;
                ce_q  <= out_q ? {cr_q[15:1], 1'b0} : cr_q;
              end else begin
                ce_q  <= ce_q[0] ? dec1 : dec2;  // odd count: single step first
              end
            end
            default: ce_q <= dec1;
          endcase
        end
      end
      if (!gate_i && (op == OP_RATE || op == OP_SQUARE)) out_q <= 1'b1;
      if (latch_stb_i && !latched_q) begin
        ol_q      <= ce_q;
        latched_q <= 1'b1;
      end
      if (rd_stb_i && ctl_q.acc != ACC_LATCH) begin
        if (ctl_q.acc == ACC_WORD) rd_hi_q <= ~rd_hi_q;
        if (ctl_q.acc != ACC_WORD || rd_hi_q) latched_q <= 1'b0;
      end
      if (wr_stb_i) begin
        case (ctl_q.acc)
          ACC_LO:   cr_q <= {8'h00, wdata_i};
          ACC_HI:   cr_q <= {wdata_i, 8'h00};
          ACC_WORD: begin
            if (wr_hi_q) cr_q[15:8] <= wdata_i;
            else         cr_q[7:0]  <= wdata_i;
            wr_hi_q <= ~wr_hi_q;
          end
          default: ;
        endcase
      end
      if (wr_done) begin
        pend_q <= 1'b1;
        if (op == OP_TC) out_q <= 1'b0;
      end
      if (cfg_stb_i) begin
        ctl_q     <= cfg_i;
        out_q     <= (decode_op(cfg_i.mode) != OP_TC);
        run_q     <= 1'b0;
        pend_q    <= 1'b0;
        wr_hi_q   <= 1'b0;
        rd_hi_q   <= 1'b0;
        latched_q <= 1'b0;
      end
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic [NUM_CH-1:0] cnt_clk_i,
  input  logic [NUM_CH-1:0] gate_i,
  output logic [NUM_CH-1:0] out_o
);
  logic [NUM_CH-1:0][7:0] rd_byte;
  logic [NUM_CH-1:0]      wr_stb, rd_stb, cfg_stb, latch_stb;
  ctl_t                   cfg;
  logic [7:0]             wdata;

  pit_bus #(.NUM_CH(NUM_CH)) i_bus (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .rd_byte_i  (rd_byte),
    .wr_stb_o   (wr_stb),
    .rd_stb_o   (rd_stb),
    .cfg_stb_o  (cfg_stb),
    .latch_stb_o(latch_stb),
    .cfg_o      (cfg),
    .wdata_o    (wdata),
    .data_o,
    .data_oe_o
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit_chan i_chan (
      .clk_i, .rst_ni,
      .cnt_clk_i  (cnt_clk_i[c]),
      .gate_i     (gate_i[c]),
      .cfg_stb_i  (cfg_stb[c]),
      .cfg_i      (cfg),
      .latch_stb_i(latch_stb[c]),
      .wr_stb_i   (wr_stb[c]),
      .rd_stb_i   (rd_stb[c]),
      .wdata_i    (wdata),
      .rd_byte_o  (rd_byte[c]),
      .out_o      (out_o[c])
    );
  end
endmodule

// File: rtl/pit_checks.sv
module pit_checks #(
  parameter int NUM_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic              data_oe_o,
  input logic [NUM_CH-1:0] cnt_clk_i,
  input logic [NUM_CH-1:0] gate_i,
  input logic [NUM_CH-1:0] out_o
);
  assert_cs_blocks_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !data_oe_o);

  assert_oe_needs_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_ni) |-> !data_oe_o);

  assert_oe_on_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cs_ni && !rd_ni) |-> data_oe_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // without count edge, bus write or gate change the output holds
    assert_out_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_clk_i[c] == $past(cnt_clk_i[c])) && (gate_i[c] == $past(gate_i[c])) &&
      wr_ni && $past(wr_ni) |=> $stable(out_o[c]));
  end
endmodule

bind prog_interval_timer pit_checks #(.NUM_CH(NUM_CH)) i_pit_checks (.*);

// File: tb/test_prog_interval_timer.sv
module test_prog_interval_timer;
  localparam int NUM_CH = 3;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0]        addr_i = '0;
  logic [7:0]        data_i = '0;
  logic [7:0]        data_o;
  logic              data_oe_o;
  logic [NUM_CH-1:0] cnt_clk_i = '0, gate_i = '1, out_o;

  int    n_chk = 0, n_err = 0;
  string q_tag[$];
  int    q_val[$];
  logic  oe_seen = 1'b0;
  logic  done = 1'b0;

  prog_interval_timer #(.NUM_CH(NUM_CH)) i_prog_interval_timer (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read byte with the queued expectation
  always @(negedge clk_i) begin
    if (data_oe_o && !oe_seen) begin
      if (q_val.size() == 0) check("R2 unexpected read data", 1, 0);
      else check(q_tag.pop_front(), int'(data_o), q_val.pop_front());
    end
    oe_seen = data_oe_o;
  end

  task automatic bus_wr(logic [1:0] a, logic [7:0] d, logic cs = 1'b0);
    @(negedge clk_i);
    addr_i = a; data_i = d; cs_ni = cs; wr_ni = 1'b0;
    @(negedge clk_i);
    wr_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic bus_rd(logic [1:0] a, int exp, string tag, logic cs = 1'b0);
    if (!cs) begin
      q_tag.push_back(tag);
      q_val.push_back(exp);
    end
    @(negedge clk_i);
    addr_i = a; cs_ni = cs; rd_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic tick(int c, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); cnt_clk_i[c] = 1'b1;
      @(negedge clk_i); cnt_clk_i[c] = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic chk_out(int c, logic exp, string tag);
    check(tag, int'(out_o[c]), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("reset out_o", int'(out_o), 7);
    check("reset data_oe_o", int'(data_oe_o), 0);

    // R13: unconfigured counter ignores writes, reads zero
    bus_wr(2'd0, 8'h55);
    tick(0);
    bus_rd(2'd0, 8'h00, "R13 unconfigured read");

    // counter 0: word access, mode 0, binary
    bus_wr(2'd3, 8'h30);
    chk_out(0, 1'b0, "R7 low after control byte");
    bus_wr(2'd0, 8'h05);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, 8'h00, "R3 old count low before edge");
    bus_rd(2'd0, 8'h00, "R3 old count high before edge");
    tick(0);
    bus_rd(2'd0, 8'h05, "R4 low byte first");
    bus_rd(2'd0, 8'h00, "R4 high byte second");
    tick(0, 3);
    bus_rd(2'd0, 8'h02, "R6 live read low");
    bus_rd(2'd0, 8'h00, "R6 live read high");
    tick(0);
    chk_out(0, 1'b0, "R7 low at count one");
    tick(0);
    chk_out(0, 1'b1, "R7 high at zero");
    tick(0);
    chk_out(0, 1'b1, "R7 high after wrap");
    bus_rd(2'd0, 8'hFF, "R7 wrap low");
    bus_rd(2'd0, 8'hFF, "R7 wrap high");

    // R5: latch, count on, second latch ignored
    bus_wr(2'd3, 8'h00);
    tick(0, 2);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, 8'hFF, "R5 frozen low");
    bus_rd(2'd0, 8'hFF, "R5 frozen high");
    bus_rd(2'd0, 8'hFD, "R5 released low");
    bus_rd(2'd0, 8'hFF, "R5 released high");

    // R4: control byte resets the pointer
    bus_rd(2'd0, 8'hFD, "R4 single low read");
    bus_wr(2'd3, 8'h30);
    bus_rd(2'd0, 8'hFD, "R4 pointer reset low");
    bus_rd(2'd0, 8'hFF, "R4 pointer reset high");
    bus_wr(2'd0, 8'h34);
    bus_wr(2'd0, 8'h12);
    tick(0);
    // R1: counter select 3 is ignored
    bus_wr(2'd3, 8'hF0);
    chk_out(0, 1'b0, "R1 select 3 leaves out0");
    bus_rd(2'd0, 8'h34, "R1 word low after select 3");
    bus_rd(2'd0, 8'h12, "R1 word high after select 3");

    // R2: deselected writes and reads have no effect
    bus_wr(2'd3, 8'h10, 1'b1);
    bus_rd(2'd0, 0, "R2 deselected read", 1'b1);
    bus_rd(2'd0, 8'h34, "R2 low after deselected ops");
    bus_rd(2'd0, 8'h12, "R2 high after deselected ops");

    // R8: counter 1, low byte only, mode 2, N=4
    bus_wr(2'd3, 8'h54);
    bus_wr(2'd1, 8'h04);
    tick(1);
    chk_out(1, 1'b1, "R8 high after load");
    begin
      logic exp_seq[7] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      for (int i = 0; i < 7; i++) begin
        tick(1);
        chk_out(1, exp_seq[i], $sformatf("R8 rate step %0d", i));
      end
    end
    bus_rd(2'd1, 8'h01, "R1 low-only read");
    bus_wr(2'd3, 8'h64);
    bus_wr(2'd1, 8'h02);
    tick(1);
    bus_rd(2'd1, 8'h02, "R1 high-only read");

    // R9: counter 2, low byte only, mode 3, N=5
    bus_wr(2'd3, 8'h96);
    bus_wr(2'd2, 8'h05);
    tick(2);
    chk_out(2, 1'b1, "R9 high after load");
    begin
      logic sq_seq[8] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      for (int i = 0; i < 8; i++) begin
        tick(2);
        chk_out(2, sq_seq[i], $sformatf("R9 square step %0d", i));
      end
    end

    // R11: low gate forces high and holds the count
    @(negedge clk_i); gate_i[2] = 1'b0;
    @(negedge clk_i);
    chk_out(2, 1'b1, "R11 gate low forces high");
    tick(2, 2);
    bus_rd(2'd2, 8'h04, "R11 count held");
    @(negedge clk_i); gate_i[2] = 1'b1;

    // R10: counter 1, word, mode 0, BCD
    bus_wr(2'd3, 8'h71);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd1, 8'h01);
    tick(1, 2);
    bus_rd(2'd1, 8'h99, "R10 0100 minus one low");
    bus_rd(2'd1, 8'h00, "R10 0100 minus one high");
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd1, 8'h00);
    tick(1, 2);
    bus_rd(2'd1, 8'h99, "R10 wrap 9999 low");
    bus_rd(2'd1, 8'h99, "R10 wrap 9999 high");

    // R12: mode 1 counts, output stays high
    bus_wr(2'd3, 8'h72);
    chk_out(1, 1'b1, "R12 high after control byte");
    bus_wr(2'd1, 8'h03);
    bus_wr(2'd1, 8'h00);
    tick(1, 4);
    chk_out(1, 1'b1, "R12 high at zero");
    bus_rd(2'd1, 8'h00, "R12 count low");
    bus_rd(2'd1, 8'h00, "R12 count high");

    repeat (4) @(negedge clk_i);
    check("all expected reads seen", q_val.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule